// File: doc/BRIEF.md
# Multiplexed Port Status LED Encoder

This block scans a set of repeater ports and shows the fault status of one port at a time on a six-bit output bus. The low four bits carry the number of the port being shown. Bit 5 shows whether that port is jabbering and bit 4 shows whether it has been auto-partitioned. Logic outside the chip watches the index, latches the two flags for each port and drives the matching LEDs. Only six pins are needed for up to sixteen ports.

The status inputs are two vectors with one bit per port. They come from the jabber and partition status registers elsewhere in the chip. A prescaler counts system clocks and produces one scan step every `TICK_DIV` cycles. With the default of 10 at a 250 MHz clock, the index moves on at 25 MHz. On each step, the index and both flags of the selected port are captured in one register stage. The bus then holds that value until the next step.

Top module: `port_led_scan`

## Requirements
- R1: While `rstN` is low, `ledBus` is all zeros, whatever the status inputs are.
- R2: `ledBus[3:0]` carries the index of the port being shown, as an unsigned binary number. Each scan step moves it up by one.
- R3: After index `NUM_PORTS-1`, the next scan step shows index 0.
- R4: `ledBus[5]` is 1 exactly when the jabber input bit of the shown port was 1 at the scan step that selected it.
- R5: `ledBus[4]` is 1 exactly when the partition input bit of the shown port was 1 at the scan step that selected it.
- R6: Scan steps occur once every `TICK_DIV` clock cycles. Between steps, `ledBus` does not change.
- R7: The index and the two flags are loaded in the same clock edge. A change of the status inputs between steps does not alter the bus until the next step.
- R8: After reset is released, the first scan step happens on the `TICK_DIV`-th rising edge and shows port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| jabStat | input | NUM_PORTS | Jabber status, one bit per port, 1 = jabbering |
| partStat | input | NUM_PORTS | Auto-partition status, one bit per port, 1 = partitioned |
| ledBus | output | 6 | {jabber flag, partition flag, port index[3:0]} |

## Verification
The bench builds the block with five ports and a prescale of three. A full scan then takes only fifteen cycles. This size means each status pattern covers a complete pass and a wrap from 4 to 0, and there are two held cycles per step to check for stability. Using a port count that is not a power of two checks the wrap at a value other than the natural rollover of the four-bit counter. A reset in the middle of a scan and a change of the status inputs between steps are driven as directed cases.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;

  localparam int IDX_W = 4;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] portSel;
  } scan_strobe_t;

endpackage

// File: rtl/ledscan_ctrl.sv
module ledscan_ctrl
  import ledscan_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int TICK_DIV  = 10
) (
  input  logic         clk,
  input  logic         rstN,
  output scan_strobe_t strobe
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

  logic             tick;
  logic [IDX_W-1:0] portIdx;

  generate
    if (TICK_DIV > 1) begin : g_prescale
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

      a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
        divCnt < DIV_W'(TICK_DIV));
    end else begin : g_noprescale
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portIdx <= '0;
    else if (tick) portIdx <= (portIdx == LAST_IDX) ? '0 : portIdx + 1'b1;
  end

  assign strobe.load    = tick;
  assign strobe.portSel = portIdx;

  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    portIdx <= LAST_IDX);
  a_r2_idx_advance: assert property (@(posedge clk) disable iff (!rstN)
    (tick && portIdx != LAST_IDX) |=> portIdx == $past(portIdx) + 1'b1);
  a_r3_idx_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && portIdx == LAST_IDX) |=> portIdx == '0);
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(portIdx));

endmodule

// File: rtl/ledscan_dp.sv
module ledscan_dp
  import ledscan_pkg::*;
#(
  parameter int NUM_PORTS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scan_strobe_t         strobe,
  input  logic [NUM_PORTS-1:0] jabStat,
  input  logic [NUM_PORTS-1:0] partStat,
  output logic [5:0]           ledBus
);

  localparam int SEL_SPAN = 1 << IDX_W;

  logic [SEL_SPAN-1:0] jabPad;
  logic [SEL_SPAN-1:0] partPad;
  logic [5:0]          outReg;

  assign jabPad  = SEL_SPAN'(jabStat);
  assign partPad = SEL_SPAN'(partStat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobe.load)
      outReg <= {jabPad[strobe.portSel], partPad[strobe.portSel], strobe.portSel};
  end

  assign ledBus = outReg;

  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |-> ledBus == '0);
  a_r4_jab_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ledBus[5] == $past(jabPad[strobe.portSel]));
  a_r5_part_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ledBus[4] == $past(partPad[strobe.portSel]));
  a_r7_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(ledBus));

endmodule

// File: rtl/port_led_scan.sv
module port_led_scan
  import ledscan_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int TICK_DIV  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] jabStat,
  input  logic [NUM_PORTS-1:0] partStat,
  output logic [5:0]           ledBus
);

  scan_strobe_t strobe;

  initial begin
    a_r2_port_count: assert (NUM_PORTS >= 1 && NUM_PORTS <= 16 && TICK_DIV >= 1);
  end

  ledscan_ctrl #(.NUM_PORTS(NUM_PORTS), .TICK_DIV(TICK_DIV)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  ledscan_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .jabStat  (jabStat),
    .partStat (partStat),
    .ledBus   (ledBus)
  );

endmodule

// File: tb/sim_port_led_scan.sv
`timescale 1ns/1ps
module sim_port_led_scan;

  localparam int NP  = 5;
  localparam int DIV = 3;
  localparam int NV  = 6;

  // each entry: {jabber[4:0], partition[4:0]}
  localparam logic [9:0] VEC [0:NV-1] = '{
    10'b00000_00000,
    10'b11111_00000,
    10'b00000_11111,
    10'b10101_01010,
    10'b00001_10000,
    10'b11111_11111
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] jab = '0;
  logic [NP-1:0] part = '0;
  logic [5:0]    ledBus;
  logic [5:0]    prevOut = '0;
  int            total = 0;
  int            bad = 0;

  always #2 clk = ~clk;

  port_led_scan #(.NUM_PORTS(NP), .TICK_DIV(DIV)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .jabStat  (jab),
    .partStat (part),
    .ledBus   (ledBus)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: ledBus=%b expected %b", req, act, exp);
    end
  endtask

  // waits one scan step; checks the hold cycles, then the newly loaded value
  task automatic stepPort(input int p, input string req);
    logic [5:0] exp;
    for (int h = 0; h < DIV - 1; h++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 R7 hold between steps", ledBus, prevOut);
    end
    @(posedge clk);
    @(negedge clk);
    exp = {jab[p], part[p], 4'(p)};
    check(req, ledBus, exp);
    prevOut = exp;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: ledBus=%b expected finish", ledBus);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    jab  = '1;
    part = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset holds zeros", ledBus, 6'b0);
    jab  = VEC[0][9:5];
    part = VEC[0][4:0];
    rstN = 1'b1;

    // table walk: one full scan per status pattern
    for (int v = 0; v < NV; v++) begin
      jab  = VEC[v][9:5];
      part = VEC[v][4:0];
      for (int p = 0; p < NP; p++) begin
        if (v == 0 && p == 0)      stepPort(p, "R8 first step shows port 0");
        else if (p == 0)           stepPort(p, "R3 wrap to port 0");
        else                       stepPort(p, "R2 R4 R5 index and flags");
      end
    end

    // R7: flip status right after a step; bus must keep old flags until next step
    jab  = 5'b00100;
    part = 5'b00010;
    stepPort(0, "R4 R5 port 0 flags");
    jab  = 5'b11011;
    part = 5'b11101;
    stepPort(1, "R7 new flags only at next step");
    stepPort(2, "R2 R4 R5 after status change");

    // R1 and R8: reset in the middle of a scan
    stepPort(3, "R2 index 3");
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset clears bus mid scan", ledBus, 6'b0);
    @(negedge clk);
    check("R1 bus stays zero in reset", ledBus, 6'b0);
    prevOut = '0;
    rstN = 1'b1;
    stepPort(0, "R8 restart at port 0");
    stepPort(1, "R2 index after restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule